// File: doc/BRIEF.md
# MDIO Station Management Controller

This block is a single-command management master for a clause-22 PHY. Software prepares one 32-bit command word (operation code, PHY address, register address, bus clock code and, for a write, the data) and writes it in one strobe. The block then toggles MDC, shifts the frame out on MDIO through an output/enable pair and, for a read, releases the line and samples the reply. When the frame ends, the completion flag, the PHY error flag and the read data appear in the same word.

The command word layout: bits 31:16 data (write data going out, read data coming back), bit 15 done, bit 14 PHY error, bits 13:12 operation (1 read, 2 write), bits 11:10 bus clock code (0 = 50 MHz, 1 = 66 MHz, 2 = 83 MHz, 3 = 100 MHz), bits 9:5 PHY address, bits 4:0 register address. The frame is 32 ones, start pattern 01, wire operation (10 read, 01 write), PHY address, register address, turnaround, then 16 data bits, each field MSB first.

The controller has five states. IDLE waits for a command and takes the transition IDLE->SEND when a valid operation is written. SEND drives the frame and takes SEND->TAIL after the last bit of a write, or SEND->TURN after the register address of a read. TURN floats the line for the two turnaround bits and takes TURN->RECV after the second. RECV samples 16 data bits and takes RECV->TAIL after the last. TAIL waits for MDC to fall and takes TAIL->IDLE, posting the results.

Top module: `mdio_station`

## Requirements
- R1: After reset the word reads 0x00008000 with MDIO not driven; writing a read (1) or write (2) command clears bit 15 on the next cycle and bit 15 sets again once the frame has ended, with bits 13:0 as written.
- R2: A write command sends exactly 64 MDC periods carrying 32 ones, 01, 01, bits 9:5, bits 4:0, 10 and bits 31:16, all driven, MSB first.
- R3: A command with operation code 0 or 3 produces no MDC pulse and reads back on the next cycle with bit 15 set, bit 14 clear and the other written fields kept.
- R4: A read command drives only the first 46 bits (32 ones, 01, 10, PHY address, register address) and leaves MDIO undriven for the turnaround and the 16 data bits.
- R5: For a read, the 16 values sampled on MDC rising edges 49 to 64 are returned in bits 31:16, MSB first, with bit 14 clear when the line was low at rising edge 48.
- R6: For a read, bit 14 is set when MDIO is high at rising edge 48 (the second turnaround bit).
- R7: A host write while bit 15 is clear is ignored: the frame in flight and the word reported at its end are unaffected.
- R8: The MDC period, in bus clocks, is 20, 28, 34 or 40 for clock codes 0, 1, 2, 3 (at most 2.5 MHz for the named bus clock), and MDC is low whenever bit 15 is set.
- R9: At clock code 3 a full command, from the write strobe to bit 15 set, takes fewer than 10000 bus clocks (100 µs at 100 MHz).
- R10: The driven MDIO value changes only one bus clock after an MDC rising edge, never on the edge itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Command word write strobe |
| host_wdata | input | 32 | Command word written by the host |
| host_rdata | output | 32 | Command/status word read by the host |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong state or bit count inside the controller shows at MDIO within one MDC period: a skipped or extra bit shifts every later field of the captured frame, and a late TURN transition leaves the enable high during the turnaround. A wrong divider selection shows on the first MDC period after the strobe. A mistake in posting results shows at the single cycle the done flag rises, as wrong read data, a wrong error bit or a clobbered field, and an accepted write during a busy frame shows as a changed word before the frame ends.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_TURN,
        ST_RECV,
        ST_TAIL
    } mdio_state_e;

    // host operation codes in the command word
    localparam logic [1:0] CMD_READ   = 2'd1;
    localparam logic [1:0] CMD_WRITE  = 2'd2;
    // operation codes on the wire
    localparam logic [1:0] WIRE_READ  = 2'b10;
    localparam logic [1:0] WIRE_WRITE = 2'b01;

    // bus clocks per MDC half period, rounded up so MDC never exceeds the limit
    function automatic int unsigned half_period(input int unsigned bus_khz,
                                                input int unsigned mdc_khz);
        return (bus_khz + 2 * mdc_khz - 1) / (2 * mdc_khz);
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int unsigned HALF_0 = 10,
    parameter int unsigned HALF_1 = 14,
    parameter int unsigned HALF_2 = 17,
    parameter int unsigned HALF_3 = 20,
    parameter int unsigned CW     = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       mdc,
    output logic       rise,
    output logic       fall
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] half_m1;
    logic          wrap;

    always_comb begin
        unique case (sel)
            2'd0: half_m1 = CW'(HALF_0 - 1);
            2'd1: half_m1 = CW'(HALF_1 - 1);
            2'd2: half_m1 = CW'(HALF_2 - 1);
            2'd3: half_m1 = CW'(HALF_3 - 1);
            default: half_m1 = CW'(HALF_3 - 1);
        endcase
    end

    assign wrap = run && (cnt == half_m1);
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_shift.sv
module mdio_shift #(
    parameter int unsigned FRAME_BITS = 64,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned IW         = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_vec,
    input  logic                  adv,
    input  logic                  cap,
    input  logic                  din,
    output logic                  tx_bit,
    output logic [IW-1:0]         idx,
    output logic [DATA_W-1:0]     rx
);

    logic [FRAME_BITS-1:0] sr;

    assign tx_bit = sr[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            idx <= '0;
        end else if (load) begin
            sr  <= load_vec;
            idx <= '0;
        end else if (adv) begin
            sr  <= {sr[FRAME_BITS-2:0], 1'b0};
            idx <= idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rx <= '0;
        else if (cap)
            rx <= {rx[DATA_W-2:0], din};
    end

endmodule

// File: rtl/mdio_station.sv
module mdio_station #(
    parameter int unsigned BUS0_KHZ    = 50000,
    parameter int unsigned BUS1_KHZ    = 66000,
    parameter int unsigned BUS2_KHZ    = 83000,
    parameter int unsigned BUS3_KHZ    = 100000,
    parameter int unsigned MDC_MAX_KHZ = 2500,
    parameter int unsigned PREAMBLE    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_pkg::*;

    localparam int unsigned ADDR_W     = 5;
    localparam int unsigned DATA_W     = 16;
    localparam int unsigned FRAME_BITS = PREAMBLE + 4 + 2 * ADDR_W + 2 + DATA_W;
    localparam int unsigned IW         = $clog2(FRAME_BITS);
    localparam int unsigned HEAD_LAST  = PREAMBLE + 4 + 2 * ADDR_W - 1;
    localparam int unsigned TA_LAST    = HEAD_LAST + 2;
    localparam int unsigned LAST_BIT   = FRAME_BITS - 1;
    localparam int unsigned HALF_0     = half_period(BUS0_KHZ, MDC_MAX_KHZ);
    localparam int unsigned HALF_1     = half_period(BUS1_KHZ, MDC_MAX_KHZ);
    localparam int unsigned HALF_2     = half_period(BUS2_KHZ, MDC_MAX_KHZ);
    localparam int unsigned HALF_3     = half_period(BUS3_KHZ, MDC_MAX_KHZ);
    localparam int unsigned HALF_MAX   = max4(HALF_0, HALF_1, HALF_2, HALF_3);
    localparam int unsigned CW         = $clog2(HALF_MAX + 1);

    mdio_state_e state, state_nxt;

    logic [31:0]           ctl;
    logic                  err_q;
    logic                  adv_q;
    logic                  rise, fall;
    logic                  tx_bit;
    logic [IW-1:0]         idx;
    logic [DATA_W-1:0]     rx;
    logic                  cmd_ok, accept, start, is_read;
    logic [1:0]            wire_op;
    logic [FRAME_BITS-1:0] frame_vec;

    assign cmd_ok  = (host_wdata[13:12] == CMD_READ) || (host_wdata[13:12] == CMD_WRITE);
    assign accept  = host_wr && (state == ST_IDLE);
    assign start   = accept && cmd_ok;
    assign is_read = (ctl[13:12] == CMD_READ);
    assign wire_op = (host_wdata[13:12] == CMD_READ) ? WIRE_READ : WIRE_WRITE;
    assign frame_vec = {{PREAMBLE{1'b1}}, 2'b01, wire_op,
                        host_wdata[9:5], host_wdata[4:0], 2'b10, host_wdata[31:16]};

    mdio_clkgen #(
        .HALF_0 (HALF_0),
        .HALF_1 (HALF_1),
        .HALF_2 (HALF_2),
        .HALF_3 (HALF_3),
        .CW     (CW)
    ) i_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .sel   (ctl[11:10]),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_shift #(
        .FRAME_BITS (FRAME_BITS),
        .DATA_W     (DATA_W),
        .IW         (IW)
    ) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_vec (frame_vec),
        .adv      (adv_q),
        .cap      (rise && (state == ST_RECV)),
        .din      (mdio_i),
        .tx_bit   (tx_bit),
        .idx      (idx),
        .rx       (rx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            adv_q <= 1'b0;
        end else begin
            state <= state_nxt;
            adv_q <= rise;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = ST_SEND;
            ST_SEND: begin
                if (adv_q && idx == IW'(LAST_BIT))
                    state_nxt = ST_TAIL;
                else if (adv_q && is_read && idx == IW'(HEAD_LAST))
                    state_nxt = ST_TURN;
            end
            ST_TURN: if (adv_q && idx == IW'(TA_LAST)) state_nxt = ST_RECV;
            ST_RECV: if (adv_q && idx == IW'(LAST_BIT)) state_nxt = ST_TAIL;
            ST_TAIL: if (fall) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // command word and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl   <= 32'h0000_8000;
            err_q <= 1'b0;
        end else begin
            if (start)
                err_q <= 1'b0;
            else if (rise && state == ST_TURN && idx == IW'(TA_LAST))
                err_q <= mdio_i;

            if (accept) begin
                ctl     <= host_wdata;
                ctl[15] <= !cmd_ok;
                ctl[14] <= 1'b0;
            end else if (state == ST_TAIL && fall) begin
                ctl[15] <= 1'b1;
                ctl[14] <= err_q;
                if (is_read)
                    ctl[31:16] <= rx;
            end
        end
    end

    // outputs
    always_comb begin
        mdio_oe    = (state == ST_SEND);
        mdio_o     = (state == ST_SEND) ? tx_bit : 1'b0;
        host_rdata = ctl;
    end

endmodule

// File: rtl/mdio_station_chk.sv
module mdio_station_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [31:0] host_wdata,
    input logic [31:0] host_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);

    logic op_valid;
    assign op_valid = (host_wdata[13:12] == 2'd1) || (host_wdata[13:12] == 2'd2);

    AST_CMD_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_rdata[15] && op_valid |=> !host_rdata[15]); // R1

    AST_BAD_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_rdata[15] && !op_valid |=> host_rdata[15] && !mdc); // R3

    AST_BUSY_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rdata[15] |=> $stable(host_rdata[13:0])); // R7

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[15] |-> !mdc && !mdio_oe); // R8

    AST_MDIO_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))
        |-> mdc && $past(mdc) && !$past(mdc, 2)); // R10

endmodule

bind mdio_station mdio_station_chk i_chk (.*);

// File: tb/test_mdio_station.sv
`timescale 1ns/1ps
module test_mdio_station;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    // PHY model state
    logic [63:0] seen;
    int          nrise, ndriven, hold_err;
    logic        phy_resp = 1'b1;
    logic [15:0] phy_data = '0;
    realtime     t_prev, last_period;

    always #5 clk = ~clk;

    mdio_station i_mdio_station (
        .clk (clk), .rst_n (rst_n), .host_wr (host_wr), .host_wdata (host_wdata),
        .host_rdata (host_rdata), .mdc (mdc), .mdio_o (mdio_o), .mdio_oe (mdio_oe),
        .mdio_i (mdio_i)
    );

    function automatic logic phy_bit(input int k);
        if (!phy_resp) return 1'b1;
        if (k == 47) return 1'b0;
        if (k >= 48 && k <= 63) return phy_data[63 - k];
        return 1'b1;
    endfunction

    always @(posedge mdc) begin
        logic v;
        v = mdio_o;
        seen = {seen[62:0], v};
        if (mdio_oe) ndriven++;
        nrise++;
        last_period = $realtime - t_prev;
        t_prev = $realtime;
        #1 mdio_i = phy_bit(nrise);
        @(negedge clk);
        if (mdio_oe && mdio_o !== v) hold_err++;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkword(input logic [15:0] d, input logic [1:0] op,
                                           input logic [1:0] code, input logic [4:0] pa,
                                           input logic [4:0] ra);
        return {d, 2'b00, op, code, pa, ra};
    endfunction

    task automatic clear_phy();
        seen = '0; nrise = 0; ndriven = 0; mdio_i = 1'b1;
    endtask

    task automatic host_write(input logic [31:0] w);
        @(negedge clk);
        host_wr = 1'b1; host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!host_rdata[15] && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset();
        check(host_rdata == 32'h0000_8000, "R1 reset word", 64'(host_rdata), 64'h8000);
        check(!mdc && !mdio_oe, "R8 idle mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_write(input logic [1:0] code, input logic [4:0] pa,
                           input logic [4:0] ra, input logic [15:0] d, input int period);
        logic [31:0] w;
        logic [63:0] exp;
        int cyc;
        w = mkword(d, 2'd2, code, pa, ra);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, d};
        clear_phy();
        host_write(w);
        check(!host_rdata[15], "R1 done cleared", 64'(host_rdata[15]), 64'd0);
        wait_done(cyc);
        check(seen == exp, "R2 write frame", seen, exp);
        check(nrise == 64 && ndriven == 64, "R2 write bit count",
              64'(nrise * 100 + ndriven), 64'(6464));
        check(host_rdata == (w | 32'h8000), "R1 write done word", 64'(host_rdata),
              64'(w | 32'h8000));
        check(last_period == real'(period * 10), "R8 mdc period",
              64'(int'(last_period)), 64'(period * 10));
        check(!mdc, "R8 mdc low after", 64'(mdc), 64'd0);
        if (code == 2'd3)
            check(cyc < 10000, "R9 transaction time", 64'(cyc), 64'd10000);
    endtask

    task automatic t_read(input bit resp, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] d);
        logic [31:0] w;
        logic [45:0] head;
        int cyc;
        w = mkword(16'h0000, 2'd1, 2'd2, pa, ra);
        head = {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra};
        clear_phy();
        phy_resp = resp; phy_data = d;
        host_write(w);
        wait_done(cyc);
        check(seen[63:18] == head, "R4 read header", 64'(seen[63:18]), 64'(head));
        check(ndriven == 46, "R4 driven bits", 64'(ndriven), 64'd46);
        if (resp) begin
            check(host_rdata[31:16] == d, "R5 read data", 64'(host_rdata[31:16]), 64'(d));
            check(host_rdata[15:0] == (w[15:0] | 16'h8000), "R5 no error",
                  64'(host_rdata[15:0]), 64'(w[15:0] | 16'h8000));
        end else begin
            check(host_rdata[14] && host_rdata[15], "R6 phy error",
                  64'(host_rdata[15:14]), 64'd3);
        end
        phy_resp = 1'b1;
    endtask

    task automatic t_badop(input logic [1:0] op);
        logic [31:0] w;
        w = mkword(16'h1234, op, 2'd1, 5'h0A, 5'h15);
        clear_phy();
        host_write(w);
        check(host_rdata == (w | 32'h8000), "R3 bad op done at once",
              64'(host_rdata), 64'(w | 32'h8000));
        repeat (60) @(negedge clk);
        check(nrise == 0, "R3 no mdc", 64'(nrise), 64'd0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] w;
        logic [63:0] exp;
        int cyc;
        w = mkword(16'h5A0F, 2'd2, 2'd0, 5'h11, 5'h02);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h02, 2'b10, 16'h5A0F};
        clear_phy();
        host_write(w);
        repeat (100) @(negedge clk);
        host_write(mkword(16'hFFFF, 2'd1, 2'd3, 5'h1F, 5'h1F));
        wait_done(cyc);
        check(host_rdata == (w | 32'h8000), "R7 busy write ignored",
              64'(host_rdata), 64'(w | 32'h8000));
        check(seen == exp, "R7 frame unaffected", seen, exp);
    endtask

    initial begin
        hold_err = 0;
        t_prev = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(2'd0, 5'h03, 5'h11, 16'hA5C3, 20);
        t_write(2'd1, 5'h1C, 5'h07, 16'h0001, 28);
        t_write(2'd2, 5'h00, 5'h1F, 16'h8000, 34);
        t_write(2'd3, 5'h15, 5'h0A, 16'hFFFE, 40);
        t_read(1'b1, 5'h1F, 5'h00, 16'h3C5A);
        t_read(1'b1, 5'h01, 5'h12, 16'h8001);
        t_read(1'b0, 5'h02, 5'h03, 16'h0000);
        t_badop(2'd0);
        t_badop(2'd3);
        t_busy_ignore();
        check(hold_err == 0, "R10 mdio stable at rise", 64'(hold_err), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule